// File: doc/BRIEF.md
# SMBus Target Register-Access Interface

This block lets a host on a two-wire SMBus/I2C bus read and write a byte-wide register file inside the chip. The SCL and SDA pins come in raw and pass through multi-flop synchronizers. Bus edges, start and stop conditions are all recognised in the system clock domain. The block answers the host only by pulling SDA low through an open-drain enable. It has no SCL output, so it can never stretch the clock.

The block keeps a register pointer across transactions. In a write transaction, the first byte after the address loads the pointer. Each later byte is written at the pointer, and the pointer then steps on by one. A read transaction returns the register at the current pointer, and the pointer steps on after each byte sent. This one mechanism covers several transaction types:
- write byte and block write;
- send byte, which sets the pointer only;
- receive byte;
- read byte, which uses a repeated start;
- block read, which runs until the host NACKs.

The register file is outside the block. It is a combinational read port addressed by `reg_addr`, plus a one-cycle write strobe.

Top module: `smb_target_regif`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop the block is idle with `sda_oe` low until the next start.
- R2: The first byte after a start is received MSB first: a 7-bit address, then a direction bit (0 = host writes, 1 = host reads). When the address equals `own_addr`, the block pulls SDA low for the whole ninth clock.
- R3: When the address does not match, the block does not acknowledge it. It then drives nothing, writes nothing and returns no data until the next start.
- R4: In a write transaction, the first byte after the address loads the pointer and is acknowledged. A stop right after that byte writes no register.
- R5: Each later byte of a write transaction is acknowledged. It produces exactly one one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increases by one.
- R6: A read transaction sends the register at the pointer MSB first, starting on the SCL low phase that follows the address acknowledge. The pointer increases by one after each byte sent, whether the host ACKs or NACKs it.
- R7: A read byte is a pointer-loading write followed by a repeated start with a read address. It returns the register at the pointer that was just loaded.
- R8: A block read continues with the next register while the host ACKs. After a NACK the block releases SDA and drives nothing until the next start.
- R9: The pointer wraps from 0xFF to 0x00, in both block writes and block reads.
- R10: The pointer resets to 0x00 and keeps its value between transactions. A receive byte with no pointer write reads at the stored pointer.
- R11: `sda_oe` changes only while the synchronized SCL is low, and the block has no means to drive SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_addr | input | 7 | Target address this block answers to |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | 8 | Register-file address (current pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-file read data at `reg_addr` |

## Verification
A wrong pointer shows up at the ports in one of two ways. During a write, the next `reg_we` pulse carries a wrong address, visible in the very cycle of the strobe. During a read, the first data bit on SDA is wrong, visible within one SCL period. A wrong bit counter or state shifts the acknowledge slot or the data bits by whole SCL clocks. The host model then sees a missing ACK or a wrong byte at the end of that byte. A drive-enable change while SCL is high would corrupt the bus at once, so the bench checks for it on every system clock.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
    localparam int DW = 8;          // data byte width
    localparam int AW = DW - 1;     // target address width
    localparam int PW = 8;          // register pointer width
    localparam int CW = $clog2(DW); // bit counter width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_RD_ACK,
        ST_RD_LOAD,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        eng_state_t     st;
        logic [CW-1:0]  cnt;
        logic [DW-1:0]  sh;
        logic [PW-1:0]  ptr;
        logic           oe;
        logic           ack_on;
        logic           rw;
        logic           first;
        logic           we;
        logic [DW-1:0]  wdata;
    } eng_regs_t;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_d, sda_pipe_q;
    logic              scl_last_d, scl_last_q;
    logic              sda_last_d, sda_last_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_raw};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_raw};
        scl_last_d = scl_pipe_q[STAGES-1];
        sda_last_d = sda_pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end

    assign scl       = scl_pipe_q[STAGES-1];
    assign sda       = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl & ~scl_last_q;
    assign scl_fall  = ~scl & scl_last_q;
    assign start_det = scl & scl_last_q & sda_last_q & ~sda;
    assign stop_det  = scl & scl_last_q & ~sda_last_q & sda;

    // R1
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
    import smbt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [AW-1:0] own_addr,
    input  logic [DW-1:0] rdata,
    output logic          sda_oe,
    output logic [PW-1:0] ptr,
    output logic [DW-1:0] wdata,
    output logic          we
);
    eng_regs_t q, d;
    logic [DW-1:0] byte_in;

    assign byte_in = {q.sh[DW-2:0], sda};

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (q.we) d.ptr = q.ptr + 1'b1;

        unique case (q.st)
            ST_ADDR: if (scl_rise) begin
                d.sh  = byte_in;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(DW-1)) begin
                    if (q.sh[AW-1:0] == own_addr) begin
                        d.rw    = sda;
                        d.first = 1'b1;
                        d.st    = ST_ACK;
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
            end
            ST_ACK: if (scl_fall) begin
                if (!q.ack_on) begin
                    d.ack_on = 1'b1;
                    d.oe     = 1'b1;
                end else begin
                    d.ack_on = 1'b0;
                    d.cnt    = '0;
                    if (q.rw) begin
                        d.sh = rdata;
                        d.oe = ~rdata[DW-1];
                        d.st = ST_RD;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_WR;
                    end
                end
            end
            ST_WR: if (scl_rise) begin
                d.sh  = byte_in;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(DW-1)) begin
                    if (q.first) begin
                        d.ptr   = PW'(byte_in);
                        d.first = 1'b0;
                    end else begin
                        d.we    = 1'b1;
                        d.wdata = byte_in;
                    end
                    d.st = ST_ACK;
                end
            end
            ST_RD: if (scl_fall) begin
                if (q.cnt == CW'(DW-1)) begin
                    d.oe = 1'b0;
                    d.st = ST_RD_ACK;
                end else begin
                    d.sh  = {q.sh[DW-2:0], 1'b0};
                    d.oe  = ~q.sh[DW-2];
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RD_ACK: if (scl_rise) begin
                d.ptr = q.ptr + 1'b1;
                d.st  = sda ? ST_IGNORE : ST_RD_LOAD;
            end
            ST_RD_LOAD: if (scl_fall) begin
                d.sh  = rdata;
                d.oe  = ~rdata[DW-1];
                d.cnt = '0;
                d.st  = ST_RD;
            end
            default: ;
        endcase

        if (start_det) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.oe     = 1'b0;
            d.ack_on = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.ack_on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, oe: 1'b0,
                   ack_on: 1'b0, rw: 1'b0, first: 1'b0, we: 1'b0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign ptr    = q.ptr;
    assign wdata  = q.wdata;
    assign we     = q.we;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl);
    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);
    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE) && !q.oe);
    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> (!q.oe && !q.we));
    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we && q.ptr == '1) |=> (q.ptr == '0));
endmodule

// File: rtl/smb_target_regif.sv
module smb_target_regif
    import smbt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [AW-1:0] own_addr,
    output logic          sda_oe,
    output logic [PW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl      (scl_s),
        .sda      (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smbt_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_s),
        .sda      (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .own_addr (own_addr),
        .rdata    (reg_rdata),
        .sda_oe   (sda_oe),
        .ptr      (reg_addr),
        .wdata    (reg_wdata),
        .we       (reg_we)
    );
endmodule

// File: tb/smb_target_regif_bench.sv
module smb_target_regif_bench;
    localparam int Q = 10;
    localparam logic [6:0] MY_ADDR = 7'h4C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_host = 1'b1;
    logic sda_host = 1'b1;
    logic sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line, scl_line;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;
    logic [15:0] wq[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = scl_host;
    assign sda_line = sda_host & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_target_regif u_smb_target_regif (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .own_addr(MY_ADDR), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            summary();
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference comparison on every clock: drive-enable timing and write strobes
    always @(negedge clk) begin
        if (rst_n) begin
            // R11: enable may only change while SCL is low
            chk(!(sda_oe != prev_oe && scl_line), "R11 oe change with SCL high", sda_oe, prev_oe);
            prev_oe = sda_oe;
            if (reg_we) begin
                if (wq.size() == 0)
                    chk(1'b0, "R4 unexpected register write", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = wq.pop_front();
                    // R5: one strobe per byte at the pointer
                    chk({reg_addr, reg_wdata} == e, "R5 write address/data", {reg_addr, reg_wdata}, e);
                end
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; wt(Q);
        scl_host = 1'b1; wt(Q);
        sda_host = 1'b0; wt(Q);
        scl_host = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; wt(Q);
        scl_host = 1'b1; wt(Q);
        sda_host = 1'b1; wt(Q);
        // R1: idle and released after stop
        chk(sda_oe == 1'b0, "R1 SDA released after stop", sda_oe, 0);
    endtask

    task automatic send8(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i]; wt(Q);
            scl_host = 1'b1; wt(2 * Q);
            scl_host = 1'b0; wt(Q);
        end
        sda_host = 1'b1; wt(Q);
        scl_host = 1'b1; wt(Q);
        ack = ~sda_line; wt(Q);
        scl_host = 1'b0; wt(Q);
    endtask

    task automatic recv8(output logic [7:0] b, input logic nack);
        sda_host = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl_host = 1'b1; wt(Q);
            b[i] = sda_line; wt(Q);
            scl_host = 1'b0;
        end
        wt(1);
        sda_host = nack; wt(Q);
        scl_host = 1'b1; wt(2 * Q);
        scl_host = 1'b0; wt(Q);
        sda_host = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n, input string tag);
        logic ack;
        logic match;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        match = (a == MY_ADDR);
        bus_start();
        send8({a, 1'b0}, ack);
        chk(ack == match, {tag, " R2/R3 address ack"}, ack, match);
        send8(p, ack);
        chk(ack == match, {tag, " R4 pointer byte ack"}, ack, match);
        if (match) ref_ptr = p;
        for (int k = 0; k < n; k++) begin
            if (match) begin
                wq.push_back({ref_ptr, dv[k]});
                ref_mem[ref_ptr] = dv[k];
                ref_ptr = ref_ptr + 8'd1;
            end
            send8(dv[k], ack);
            chk(ack == match, {tag, " R5 data byte ack"}, ack, match);
        end
        bus_stop();
        wt(4);
        chk(wq.size() == 0, {tag, " R4/R5 all expected writes seen"}, wq.size(), 0);
    endtask

    task automatic do_read(input logic [6:0] a, input logic use_ptr, input logic [7:0] p,
                           input int n, input string tag);
        logic ack;
        logic match;
        logic [7:0] b, e;
        match = (a == MY_ADDR);
        if (use_ptr) begin
            bus_start();
            send8({a, 1'b0}, ack);
            send8(p, ack);
            if (match) ref_ptr = p;
        end
        bus_start();
        send8({a, 1'b1}, ack);
        chk(ack == match, {tag, " R2/R3 read address ack"}, ack, match);
        for (int k = 0; k < n; k++) begin
            recv8(b, k == n - 1);
            e = match ? ref_mem[ref_ptr] : 8'hFF;
            chk(b == e, {tag, " R6 read data"}, b, e);
            if (match) ref_ptr = ref_ptr + 8'd1;
        end
        // R8: nothing driven after the final NACK
        wt(2 * Q);
        chk(sda_oe == 1'b0, {tag, " R8 released after NACK"}, sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        ref_ptr = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(3);
        // R10 / R1 / R5 reset state
        chk(reg_addr == 8'h00, "R10 pointer reset value", reg_addr, 0);
        chk(sda_oe == 1'b0, "R1 SDA released at reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R5 no strobe at reset", reg_we, 0);

        do_read(MY_ADDR, 1'b0, 8'h00, 1, "R10 receive byte after reset");
        do_write(MY_ADDR, 8'h10, 8'hA5, 8'h00, 8'h00, 1, "R5 write byte");
        do_write(MY_ADDR, 8'h20, 8'h00, 8'h00, 8'h00, 0, "R4 send byte");
        chk(reg_addr == 8'h20, "R4 pointer loaded by send byte", reg_addr, 8'h20);
        do_read(MY_ADDR, 1'b0, 8'h00, 1, "R10 receive byte at stored pointer");
        do_read(MY_ADDR, 1'b1, 8'h10, 1, "R7 read byte with repeated start");
        do_write(MY_ADDR, 8'hFE, 8'h5A, 8'hC3, 8'h81, 3, "R9 block write wrap");
        chk(reg_addr == 8'h01, "R9 pointer after wrapping write", reg_addr, 8'h01);
        do_read(MY_ADDR, 1'b1, 8'hFD, 4, "R8 R9 block read wrap");
        chk(reg_addr == 8'h01, "R6 pointer after block read", reg_addr, 8'h01);
        do_write(7'h2A, 8'h30, 8'h11, 8'h22, 8'h00, 2, "R3 foreign write");
        chk(reg_addr == 8'h01, "R3 pointer untouched by foreign write", reg_addr, 8'h01);
        do_read(7'h2A, 1'b0, 8'h00, 2, "R3 foreign read");
        do_read(MY_ADDR, 1'b0, 8'h00, 2, "R10 block receive after foreign traffic");
        do_read(MY_ADDR, 1'b1, 8'hFF, 2, "R7 R9 read at last register");

        wt(20);
        summary();
    end
endmodule